// File: doc/BRIEF.md
# Run-Gated Event Time Stamp Counter

This block keeps a free-running 64-bit event clock that only advances while the acquisition run is active. Each count step comes from a one-cycle tick produced elsewhere on the chip, nominally at 10 MHz. A configuration bit can switch the source to an asynchronous external clock line. The run-state level `go` vetoes every step, so the count is frozen before a run starts and after it ends. That keeps several crates that share the same gated tick in step.

On every accepted trigger, the present count is copied into a holding register. The configuration picks which event does this: the internal live trigger or an asynchronous external latch line. Readout reads the held value in 16-bit slices chosen by a small sub-address. A software strobe or an external clear line returns the counter to zero. The vetoed tick and the capture strobe are driven out, so that follower time-stamp modules count and latch on exactly the same events.

Top module: `tstamp_counter`

## Requirements
- R1: After synchronous active-low reset, the counter and the holding register are zero, so every readout slice reads 0.
- R2: While `go` is high and `sel_ext_clk` is 0, the counter rises by one at each clock edge where `tick_int` is high.
- R3: While `go` is low, the counter does not change whatever the tick sources do, and `gated_tick_out` stays low.
- R4: `gated_tick_out` is high in exactly those cycles in which the counter advances; with the internal source this is `go & tick_int`.
- R5: With `sel_ext_clk` at 1, each rising edge of `ext_clk_in` adds exactly one count, a few cycles after the edge (double-flop synchronizer plus edge detect), and `tick_int` is ignored.
- R6: With `sel_ext_latch` at 0, a `live_trig` cycle copies the counter value present in that cycle (before any increment at that edge) into the holding register, and `latch_out` is high in that cycle.
- R7: With `sel_ext_latch` at 1, a rising edge of `ext_latch_in` performs the capture, and `live_trig` neither changes the held value nor raises `latch_out`.
- R8: A `sw_clear` cycle, or a synchronized rising edge of `ext_clear_in`, sets the counter to zero at the next edge; clear wins over a count step in the same cycle.
- R9: `rd_data` returns held bits 15:0, 31:16, 47:32 and 63:48 for `rd_sel` values 1, 2, 3 and 4 respectively, and 0 for any other `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Run-active level; vetoes counting when low |
| tick_int | input | 1 | Internal one-cycle count tick |
| ext_clk_in | input | 1 | Asynchronous external count clock |
| sel_ext_clk | input | 1 | 1 selects the external count clock |
| live_trig | input | 1 | One-cycle live trigger strobe |
| ext_latch_in | input | 1 | Asynchronous external latch line |
| sel_ext_latch | input | 1 | 1 selects the external latch line |
| sw_clear | input | 1 | One-cycle software clear |
| ext_clear_in | input | 1 | Asynchronous external clear line |
| rd_sel | input | 3 | Readout slice select (1..4) |
| rd_data | output | 16 | Selected slice of the held value |
| gated_tick_out | output | 1 | Vetoed count step for follower modules |
| latch_out | output | 1 | Capture strobe for follower modules |

## Verification
The hardest thing to reach from the ports is a nonzero upper slice. Before anything above bit 15 can be seen, the counter has to pass 65535 real steps. The stimulus does this by holding the internal tick and `go` high for 65541 consecutive cycles. The low and second slices are then read back as 5 and 1. The asynchronous lines are driven as slow pulses, each lasting several clocks, so that each edge leaves the synchronizer as exactly one pulse. Each comparison is made only after the pipeline has settled. Ignored triggers are checked by capturing, changing the count, firing the ignored strobe, and then reading the unchanged held value.

// File: rtl/ts_pkg.sv
// Package: shared widths and the readout slice type for the time stamp block.
package ts_pkg;
    localparam int TS_CNT_W  = 64;
    localparam int TS_WORD_W = 16;
    typedef logic [TS_WORD_W-1:0] ts_word_t;
endpackage

// File: rtl/ts_edge_sync.sv
// Module: ts_edge_sync
// Brings one asynchronous line into the clk domain through STAGES flops and
// emits a one-cycle pulse per rising edge. Assumes the line holds each level
// for longer than one clk period.
module ts_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES:0] sr_q;

    // Shift the line through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-1:0], async_in};
    end

    // Rising edge: newest synchronized sample high, older one low.
    assign rise_pulse = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/ts_count.sv
// Module: ts_count
// Counter with a synchronous clear that has priority over the step enable.
// It wraps silently at full scale. Assumes enable and clear are clk-domain
// single-cycle qualifiers.
module ts_count #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    // Clear first, otherwise advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (step) cnt <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/ts_capture.sv
// Module: ts_capture
// Holding register loaded on a capture strobe. The held value is presented
// as NWORDS slices of WORD_W bits, selected by sub-address 1..NWORDS with
// slice 1 the least significant. Any other sub-address reads zero.
module ts_capture #(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 16,
    localparam int NWORDS = CNT_W / WORD_W,
    localparam int SEL_W  = $clog2(NWORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [CNT_W-1:0]  hold,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] slice [NWORDS];

    // Load the live count on each capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   hold <= '0;
        else if (cap) hold <= cnt;
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_slice
        assign slice[g] = hold[g*WORD_W +: WORD_W];
    end

    // Select a slice by its 1-based sub-address.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NWORDS; i++) begin
            if (rd_sel == SEL_W'(i + 1)) rd_data = slice[i];
        end
    end
endmodule

// File: rtl/tstamp_counter.sv
// Module: tstamp_counter (top)
// Run-gated time stamp counter. The count step is the internal tick or a
// synchronized external clock edge, and it is vetoed by go. Capture comes
// from the live trigger or a synchronized external latch edge. Clear comes
// from software or a synchronized external line. The vetoed step and the
// capture strobe are driven out for follower modules.
module tstamp_counter #(
    parameter int CNT_W       = ts_pkg::TS_CNT_W,
    parameter int WORD_W      = ts_pkg::TS_WORD_W,
    parameter int SYNC_STAGES = 2,
    localparam int NWORDS = CNT_W / WORD_W,
    localparam int SEL_W  = $clog2(NWORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              tick_int,
    input  logic              ext_clk_in,
    input  logic              sel_ext_clk,
    input  logic              live_trig,
    input  logic              ext_latch_in,
    input  logic              sel_ext_latch,
    input  logic              sw_clear,
    input  logic              ext_clear_in,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic              gated_tick_out,
    output logic              latch_out
);
    localparam int N_ASYNC = 3;

    logic [N_ASYNC-1:0] async_lines;
    logic [N_ASYNC-1:0] async_rise;
    logic               cnt_en;
    logic               clr_any;
    logic               cap_any;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   hold_q;

    assign async_lines = {ext_clear_in, ext_latch_in, ext_clk_in};

    for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
        ts_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .async_in  (async_lines[g]),
            .rise_pulse(async_rise[g])
        );
    end

    // Choose the step source, then apply the run veto.
    assign cnt_en  = go & (sel_ext_clk ? async_rise[0] : tick_int);
    // Choose the capture source.
    assign cap_any = sel_ext_latch ? async_rise[1] : live_trig;
    // Either clear source zeroes the counter.
    assign clr_any = sw_clear | async_rise[2];

    ts_count #(.CNT_W(CNT_W)) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .step (cnt_en),
        .clr  (clr_any),
        .cnt  (cnt_q)
    );

    ts_capture #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap_any),
        .cnt    (cnt_q),
        .rd_sel (rd_sel),
        .hold   (hold_q),
        .rd_data(rd_data)
    );

    assign gated_tick_out = cnt_en;
    assign latch_out      = cap_any;
endmodule

// File: rtl/ts_checker.sv
// Module: ts_checker
// Temporal checks on the time stamp counter, attached through bind below.
module ts_checker #(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 16,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              go,
    input logic              en,
    input logic              clr,
    input logic              cap,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  hold,
    input logic              gated_tick_out,
    input logic [SEL_W-1:0]  rd_sel,
    input logic [WORD_W-1:0] rd_data
);
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(cnt));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && en) |=> (cnt == $past(cnt) + CNT_W'(1)));

    assert_veto_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !go |-> !gated_tick_out);

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (hold == $past(cnt)));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == '0) |-> (rd_data == '0));
endmodule

bind tstamp_counter ts_checker #(
    .CNT_W (CNT_W),
    .WORD_W(WORD_W),
    .SEL_W (SEL_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .go            (go),
    .en            (cnt_en),
    .clr           (clr_any),
    .cap           (cap_any),
    .cnt           (cnt_q),
    .hold          (hold_q),
    .gated_tick_out(gated_tick_out),
    .rd_sel        (rd_sel),
    .rd_data       (rd_data)
);

// File: tb/tstamp_counter_tb.sv
module tstamp_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0, tick_int = 1'b0, ext_clk_in = 1'b0, sel_ext_clk = 1'b0;
    logic        live_trig = 1'b0, ext_latch_in = 1'b0, sel_ext_latch = 1'b0;
    logic        sw_clear = 1'b0, ext_clear_in = 1'b0;
    logic [2:0]  rd_sel = 3'd0;
    logic [15:0] rd_data;
    logic        gated_tick_out, latch_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] exp_cnt = '0;
    logic [63:0] exp_hold = '0;
    logic        mon_req = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    tstamp_counter u_dut (
        .clk(clk), .rst_n(rst_n), .go(go), .tick_int(tick_int),
        .ext_clk_in(ext_clk_in), .sel_ext_clk(sel_ext_clk),
        .live_trig(live_trig), .ext_latch_in(ext_latch_in),
        .sel_ext_latch(sel_ext_latch), .sw_clear(sw_clear),
        .ext_clear_in(ext_clear_in), .rd_sel(rd_sel), .rd_data(rd_data),
        .gated_tick_out(gated_tick_out), .latch_out(latch_out)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each requested readout slice against the queue head.
    always @(negedge clk) begin
        if (mon_req && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {48'd0, rd_data}, {48'd0, e});
        end
    end

    task automatic read_sel(input logic [2:0] s, input logic [15:0] e, input string tag);
        @(posedge clk); #1;
        rd_sel = s;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic read_all(input string tag);
        for (int i = 1; i <= 4; i++) read_sel(3'(i), exp_hold[(i-1)*16 +: 16], tag);
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #1;
        tick_int = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_int = 1'b0;
        if (go && !sel_ext_clk) exp_cnt += 64'(n);
    endtask

    task automatic live_capture(input string tag, input logic exp_strobe);
        @(posedge clk); #1;
        live_trig = 1'b1;
        #5 chk(tag, {63'd0, latch_out}, {63'd0, exp_strobe});
        @(posedge clk); #1;
        live_trig = 1'b0;
        if (!sel_ext_latch) exp_hold = exp_cnt;
    endtask

    task automatic slow_pulse(ref logic line);
        @(posedge clk); #1;
        line = 1'b1;
        repeat (4) @(posedge clk);
        #1 line = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        read_all("R1 reset slices");

        // R3: ticks with go low are ignored and not driven out
        @(posedge clk); #1 tick_int = 1'b1;
        #5 chk("R3 veto out", {63'd0, gated_tick_out}, 64'd0);
        @(posedge clk); #1 tick_int = 1'b0;
        ticks(7);
        live_capture("R6 strobe", 1'b1);
        read_all("R3 no count while idle");

        // R2/R4: counting with go high
        go = 1'b1;
        @(posedge clk); #1 tick_int = 1'b1;
        #5 chk("R4 gated out", {63'd0, gated_tick_out}, 64'd1);
        @(posedge clk); #1 tick_int = 1'b0;
        exp_cnt += 1;
        ticks(9);
        live_capture("R6 strobe", 1'b1);
        read_all("R2 internal count");

        // R8: clear wins over a step in the same cycle
        @(posedge clk); #1 tick_int = 1'b1; sw_clear = 1'b1;
        @(posedge clk); #1 tick_int = 1'b0; sw_clear = 1'b0;
        exp_cnt = 0;
        live_capture("R6 strobe", 1'b1);
        read_all("R8 sw clear priority");

        // R9: long run to reach the second slice
        ticks(65541);
        live_capture("R6 strobe", 1'b1);
        read_all("R9 slice order");
        read_sel(3'd0, 16'd0, "R9 sub-address 0");
        read_sel(3'd5, 16'd0, "R9 sub-address 5");
        read_sel(3'd7, 16'd0, "R9 sub-address 7");

        // R8: external clear line
        slow_pulse(ext_clear_in);
        exp_cnt = 0;
        live_capture("R6 strobe", 1'b1);
        read_all("R8 ext clear");

        // R5: external clock, internal tick ignored
        sel_ext_clk = 1'b1;
        ticks(5);
        for (int k = 0; k < 6; k++) slow_pulse(ext_clk_in);
        exp_cnt += 6;
        live_capture("R6 strobe", 1'b1);
        read_all("R5 ext clock");
        sel_ext_clk = 1'b0;

        // R7: external latch, live trigger ignored
        sel_ext_latch = 1'b1;
        ticks(3);
        slow_pulse(ext_latch_in);
        exp_hold = exp_cnt;
        read_all("R7 ext latch capture");
        ticks(4);
        live_capture("R7 live strobe ignored", 1'b0);
        read_all("R7 live ignored");
        slow_pulse(ext_latch_in);
        exp_hold = exp_cnt;
        read_all("R7 second ext latch");

        // R3: go low freezes the count again
        go = 1'b0;
        ticks(11);
        sel_ext_latch = 1'b0;
        live_capture("R6 strobe", 1'b1);
        read_all("R3 frozen after run");

        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule